// File: doc/BRIEF.md
# Single-Wire LED Pixel Serializer

This block drives a chain of addressable RGB LEDs over a single data wire that carries no clock. Each bit is encoded as a pulse on the line. The line rises at the start of every bit period. A zero bit holds it high for a short time and a one bit holds it high for a longer time. The bit period has a fixed length. The three timing points are parameters counted in clock cycles.

A frame is launched with a one-cycle start request. The request carries a 16-bit pixel count, an 8-bit brightness factor and a mode: stream, repeat-one-colour, or all-zero. In stream mode, pixels are taken from a valid/ready source. Each 24-bit pixel is scaled per channel by the brightness factor. Its three channels are then permuted into the wire order chosen by a parameter and shifted out most significant bit first. The next pixel is fetched and scaled while the current one is on the wire, so bits follow back to back. After the frame, the block holds the line low for a minimum latch time before it accepts another start.

Top module: `pixel_wire_tx`

## Requirements
- R1: After reset, `dout`, `busy`, `done`, `pix_ready` and `underrun` are all low.
- R2: Every bit starts with a rising edge of `dout`. A 0 bit stays high for T1 cycles and a 1 bit stays high for T1+T2 cycles. Within a frame, successive rising edges are exactly T1+T2+T3 cycles apart.
- R3: Each pixel gives 24 bits on the wire, each channel MSB first. `pix_data` holds red in [23:16], green in [15:8] and blue in [7:0]. The wire channel order comes from the `ORDER` parameter (0 = R,G,B, the default; 1 = G,R,B; 2 = B,R,G; 3 = R,B,G; 4 = G,B,R; 5 = B,G,R).
- R4: Each channel byte v is sent as floor(v·s/256), where s is the `bright` value captured with the start request.
- R5: `done` is a one-cycle pulse. It rises 24·N·(T1+T2+T3)−1 cycles after the first rising edge of `dout` in a frame of N pixels.
- R6: `busy` rises in the cycle after an accepted start. Counting the `done` cycle, it stays high for exactly `LATCH_CYC` cycles after `done`. A start request while `busy` is high is ignored.
- R7: In stream mode (`mode` = 0), exactly N pixels are taken from the source, and they are sent in arrival order.
- R8: In repeat mode (`mode` = 1), exactly one pixel is taken from the source, and it is sent N times.
- R9: In clear mode (`mode` = 2 or 3), no pixel is taken from the source, and N all-zero pixels are sent.
- R10: A start with a pixel count of zero sends no bit and gives no `done`. `busy` is high for exactly `LATCH_CYC` cycles.
- R11: If in stream mode no next pixel has been taken when the current pixel ends, `underrun` pulses for one cycle and the frame stops with no `done`. Counting that cycle, `busy` stays high for `LATCH_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request, taken only while idle |
| pix_count | input | CNT_W | Number of pixels in the frame |
| bright | input | 8 | Brightness factor |
| mode | input | 2 | 0 stream, 1 repeat colour, 2/3 clear |
| pix_valid | input | 1 | Source pixel valid |
| pix_data | input | 24 | Source pixel, R[23:16] G[15:8] B[7:0] |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| dout | output | 1 | Serial LED data line |
| busy | output | 1 | Frame or latch wait in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| underrun | output | 1 | One-cycle pulse when the source ran dry |

## Verification
The `dout` line is registered one cycle behind the internal bit phase. So the first rising edge appears one cycle after sending begins, and `done` appears 24·N·P−1 cycles after that edge. `busy` is high the cycle after start, and it lasts `LATCH_CYC` cycles counted from the `done` or `underrun` cycle. The bench samples every output on the falling clock edge. It measures each high pulse width and each rise-to-rise spacing as it happens, and it timestamps `done` against the first observed rise. Expected intervals are therefore checked against observed events rather than absolute cycle numbers. Handshakes are counted at the falling edge that precedes the rising edge where they take effect.

// File: rtl/pixel_wire_pkg.sv
package pixel_wire_pkg;

    typedef enum logic [1:0] {
        MODE_STREAM = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_CLEAR  = 2'd2
    } tx_mode_e;

    typedef enum logic [2:0] {
        ORD_RGB = 3'd0,
        ORD_GRB = 3'd1,
        ORD_BRG = 3'd2,
        ORD_RBG = 3'd3,
        ORD_GBR = 3'd4,
        ORD_BGR = 3'd5
    } chan_order_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEND,
        ST_GAP
    } tx_state_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    // floor(v * s / 256) built as eight conditional shifted additions
    function automatic logic [7:0] scale_byte(input logic [7:0] v, input logic [7:0] s);
        logic [15:0] acc;
        acc = '0;
        for (int i = 0; i < 8; i++) begin
            if (s[i]) acc = acc + ({8'd0, v} << i);
        end
        return acc[15:8];
    endfunction

    function automatic logic [23:0] reorder(input rgb_t p, input chan_order_e ord);
        logic [23:0] w;
        case (ord)
            ORD_GRB: w = {p.g, p.r, p.b};
            ORD_BRG: w = {p.b, p.r, p.g};
            ORD_RBG: w = {p.r, p.b, p.g};
            ORD_GBR: w = {p.g, p.b, p.r};
            ORD_BGR: w = {p.b, p.g, p.r};
            default: w = {p.r, p.g, p.b};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pwt_scaler.sv
module pwt_scaler
    import pixel_wire_pkg::*;
#(
    parameter chan_order_e ORDER = ORD_RGB
) (
    input  logic [23:0] raw,
    input  logic [7:0]  factor,
    output logic [23:0] wire_word
);
    localparam int NCH = 3;

    logic [23:0] scaled;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign scaled[c*8 +: 8] = scale_byte(raw[c*8 +: 8], factor);
    end

    assign wire_word = reorder(rgb_t'(scaled), ORDER);

endmodule

// File: rtl/pwt_bit_timer.sv
module pwt_bit_timer #(
    parameter int T1 = 3,
    parameter int T2 = 4,
    parameter int T3 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic bit_val,
    output logic bit_end,
    output logic line
);
    localparam int P  = T1 + T2 + T3;
    localparam int PW = (P > 2) ? $clog2(P) : 1;
    localparam logic [PW-1:0] LAST  = PW'(P - 1);
    localparam logic [PW-1:0] HI_Z  = PW'(T1);
    localparam logic [PW-1:0] HI_O  = PW'(T1 + T2);

    logic [PW-1:0] phase_q;
    logic          line_q;

    assign bit_end = run && (phase_q == LAST);
    assign line    = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            line_q  <= 1'b0;
        end else begin
            if (!run || bit_end) phase_q <= '0;
            else                 phase_q <= phase_q + 1'b1;
            line_q <= run && (phase_q < (bit_val ? HI_O : HI_Z));
        end
    end

    p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);

    p_line_low_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> !line_q);

endmodule

// File: rtl/pixel_wire_tx.sv
module pixel_wire_tx
    import pixel_wire_pkg::*;
#(
    parameter int          T1        = 3,
    parameter int          T2        = 4,
    parameter int          T3        = 3,
    parameter int          LATCH_CYC = 2400,
    parameter int          CNT_W     = 16,
    parameter chan_order_e ORDER     = ORD_RGB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pix_count,
    input  logic [7:0]       bright,
    input  logic [1:0]       mode,
    input  logic             pix_valid,
    input  logic [23:0]      pix_data,
    output logic             pix_ready,
    output logic             dout,
    output logic             busy,
    output logic             done,
    output logic             underrun
);
    localparam int GW = $clog2(LATCH_CYC + 1);
    localparam logic [GW-1:0]    GAP_LAST = GW'(LATCH_CYC - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [4:0]       BIT_LAST = 5'd23;

    tx_state_e        state_q;
    tx_mode_e         mode_q, mode_in;
    logic [7:0]       bright_q;
    logic [CNT_W-1:0] send_left_q, fetch_left_q;
    logic [23:0]      shr_q, next_q, color_q;
    logic             next_full_q;
    logic [4:0]       bit_idx_q;
    logic [GW-1:0]    gap_q;
    logic             done_q, urun_q;

    logic [23:0]      scaled;
    logic             bit_end, fire, pix_end;

    always_comb begin
        case (mode)
            2'd0:    mode_in = MODE_STREAM;
            2'd1:    mode_in = MODE_REPEAT;
            default: mode_in = MODE_CLEAR;
        endcase
    end

    pwt_scaler #(.ORDER(ORDER)) u_scale (
        .raw      (pix_data),
        .factor   (bright_q),
        .wire_word(scaled)
    );

    pwt_bit_timer #(.T1(T1), .T2(T2), .T3(T3)) u_bits (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == ST_SEND),
        .bit_val(shr_q[23]),
        .bit_end(bit_end),
        .line   (dout)
    );

    assign pix_ready = ((state_q == ST_LOAD) && (mode_q != MODE_CLEAR)) ||
                       ((state_q == ST_SEND) && (mode_q == MODE_STREAM) &&
                        !next_full_q && (fetch_left_q != '0));
    assign fire     = pix_valid && pix_ready;
    assign pix_end  = bit_end && (bit_idx_q == BIT_LAST);
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign underrun = urun_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            mode_q       <= MODE_STREAM;
            bright_q     <= '0;
            send_left_q  <= '0;
            fetch_left_q <= '0;
            shr_q        <= '0;
            next_q       <= '0;
            color_q      <= '0;
            next_full_q  <= 1'b0;
            bit_idx_q    <= '0;
            gap_q        <= '0;
            done_q       <= 1'b0;
            urun_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            urun_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q       <= mode_in;
                        bright_q     <= bright;
                        send_left_q  <= pix_count;
                        fetch_left_q <= (mode_in == MODE_STREAM) ? pix_count : '0;
                        next_full_q  <= 1'b0;
                        bit_idx_q    <= '0;
                        color_q      <= '0;
                        gap_q        <= '0;
                        state_q      <= (pix_count == '0) ? ST_GAP : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (mode_q == MODE_CLEAR) begin
                        shr_q   <= '0;
                        state_q <= ST_SEND;
                    end else if (fire) begin
                        shr_q   <= scaled;
                        color_q <= scaled;
                        if (mode_q == MODE_STREAM) fetch_left_q <= fetch_left_q - 1'b1;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (fire) fetch_left_q <= fetch_left_q - 1'b1;
                    if (bit_end && !pix_end) begin
                        shr_q     <= shr_q << 1;
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                    if (pix_end) begin
                        bit_idx_q <= '0;
                        if (send_left_q == ONE) begin
                            done_q  <= 1'b1;
                            gap_q   <= '0;
                            state_q <= ST_GAP;
                        end else begin
                            send_left_q <= send_left_q - 1'b1;
                            if (mode_q != MODE_STREAM) begin
                                shr_q <= color_q;
                            end else if (next_full_q) begin
                                shr_q       <= next_q;
                                next_full_q <= 1'b0;
                            end else if (fire) begin
                                shr_q <= scaled;
                            end else begin
                                urun_q  <= 1'b1;
                                gap_q   <= '0;
                                state_q <= ST_GAP;
                            end
                        end
                    end else if (fire) begin
                        next_q      <= scaled;
                        next_full_q <= 1'b1;
                    end
                end
                default: begin
                    if (gap_q == GAP_LAST) state_q <= ST_IDLE;
                    else                   gap_q   <= gap_q + 1'b1;
                end
            endcase
        end
    end

    p_line_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !dout);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_on_start_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_ready_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> busy);

    p_clear_no_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && (mode_q == MODE_CLEAR)) |-> !pix_ready);

    p_urun_no_done_r11: assert property (@(posedge clk) disable iff (rst)
        !(done && underrun));

endmodule

// File: tb/sim_pixel_wire_tx.sv
module sim_pixel_wire_tx;
    import pixel_wire_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int T1 = 2, T2 = 3, T3 = 2;
    localparam int P = T1 + T2 + T3;
    localparam int LATCH = 40;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [15:0] pix_count = '0;
    logic [7:0]  bright = '0;
    logic [1:0]  mode = '0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        pix_ready, dout, busy, done, underrun;

    pixel_wire_tx #(.T1(T1), .T2(T2), .T3(T3), .LATCH_CYC(LATCH),
                    .CNT_W(16), .ORDER(ORD_GRB)) u0 (
        .clk(clk), .rst(rst), .start(start), .pix_count(pix_count),
        .bright(bright), .mode(mode), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_ready(pix_ready), .dout(dout),
        .busy(busy), .done(done), .underrun(underrun));

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    int vecs = 0, errs = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // pixel source
    logic [23:0] src_mem [8];
    int src_idx = 0, src_lim = 0, hs_n = 0;
    bit src_on = 0;

    initial forever begin
        bit f;
        @(negedge clk);
        f = pix_valid && pix_ready;
        if (f) hs_n++;
        @(posedge clk);
        #1;
        if (f) src_idx++;
        pix_valid = src_on && (src_idx < src_lim);
        pix_data  = src_mem[(src_idx < 8) ? src_idx : 0];
    end

    // line monitor
    int mcyc = 0, rises = 0, last_rise = 0, rise0 = 0, hi_run = 0;
    int rx_bits = 0, done_n = 0, done_cyc = 0, urun_n = 0, busy_n = 0, tail_n = 0;
    bit tail_on = 0;
    logic prev_line = 1'b0;
    logic [23:0] rx_pix [16];

    task automatic push_bit(input logic b);
        if (rx_bits < 16*24) rx_pix[rx_bits/24] = {rx_pix[rx_bits/24][22:0], b};
        rx_bits++;
    endtask

    initial forever begin
        @(negedge clk);
        mcyc++;
        if (dout && !prev_line) begin
            if (rises > 0) chk(mcyc - last_rise == P, "R2", "rise spacing", mcyc - last_rise, P);
            else rise0 = mcyc;
            rises++;
            last_rise = mcyc;
            hi_run = 0;
        end
        if (dout) hi_run++;
        if (!dout && prev_line) begin
            if (hi_run == T1) push_bit(1'b0);
            else if (hi_run == T1 + T2) push_bit(1'b1);
            else chk(0, "R2", "pulse width", hi_run, T1);
        end
        prev_line = dout;
        if (done) begin done_n++; done_cyc = mcyc; tail_on = 1; end
        if (underrun) begin urun_n++; tail_on = 1; end
        if (busy) busy_n++;
        if (busy && tail_on) tail_n++;
    end

    task automatic clear_mon();
        rises = 0; rx_bits = 0; done_n = 0; urun_n = 0;
        busy_n = 0; tail_n = 0; tail_on = 0; hs_n = 0;
        for (int i = 0; i < 16; i++) rx_pix[i] = '0;
    endtask

    function automatic logic [23:0] exp_word(input logic [23:0] p, input logic [7:0] s);
        int r, g, b;
        r = (int'(p[23:16]) * int'(s)) / 256;
        g = (int'(p[15:8])  * int'(s)) / 256;
        b = (int'(p[7:0])   * int'(s)) / 256;
        return {g[7:0], r[7:0], b[7:0]};   // G,R,B wire order under test
    endfunction

    task automatic wait_idle();
        int w = 0;
        while (busy && w < 20000) begin @(negedge clk); w++; end
    endtask

    task automatic launch(input logic [1:0] m, input int n, input logic [7:0] s, input int lim);
        @(negedge clk);
        src_idx = 0; src_lim = lim; src_on = 1;
        clear_mon();
        @(negedge clk);
        mode = m; pix_count = 16'(n); bright = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6", "busy after start", busy, 1);
    endtask

    task automatic finish_frame();
        wait_idle();
        src_on = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(dout == 0 && busy == 0 && done == 0 && pix_ready == 0 && underrun == 0,
            "R1", "outputs in reset", {dout, busy, done, pix_ready, underrun}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(dout == 0 && busy == 0 && pix_ready == 0, "R1", "outputs after reset",
            {dout, busy, pix_ready}, 0);
    endtask

    task automatic t_stream(input int n, input logic [7:0] s);
        launch(2'd0, n, s, 8);
        finish_frame();
        chk(rx_bits == 24*n, "R3", "bit count", rx_bits, 24*n);
        chk(rises == 24*n, "R2", "rising edges", rises, 24*n);
        for (int i = 0; i < n; i++)
            chk(rx_pix[i] == exp_word(src_mem[i], s), "R4", "stream pixel", rx_pix[i], exp_word(src_mem[i], s));
        chk(hs_n == n, "R7", "handshakes", hs_n, n);
        chk(done_n == 1, "R5", "done count", done_n, 1);
        chk(done_cyc - rise0 == 24*n*P - 1, "R5", "done timing", done_cyc - rise0, 24*n*P - 1);
        chk(tail_n == LATCH, "R6", "latch cycles", tail_n, LATCH);
        chk(urun_n == 0, "R11", "no underrun", urun_n, 0);
    endtask

    task automatic t_repeat();
        launch(2'd1, 3, 8'd200, 8);
        finish_frame();
        chk(hs_n == 1, "R8", "one fetch", hs_n, 1);
        chk(rx_bits == 72, "R8", "bit count", rx_bits, 72);
        for (int i = 0; i < 3; i++)
            chk(rx_pix[i] == exp_word(src_mem[0], 8'd200), "R8", "repeated pixel", rx_pix[i], exp_word(src_mem[0], 8'd200));
    endtask

    task automatic t_clear();
        launch(2'd2, 2, 8'd255, 8);
        finish_frame();
        chk(hs_n == 0, "R9", "no fetch", hs_n, 0);
        chk(rx_bits == 48, "R9", "bit count", rx_bits, 48);
        chk(rx_pix[0] == 0 && rx_pix[1] == 0, "R9", "zero pixels", rx_pix[0] | rx_pix[1], 0);
        chk(done_n == 1, "R9", "done", done_n, 1);
    endtask

    task automatic t_zero();
        launch(2'd0, 0, 8'd255, 8);
        finish_frame();
        chk(rises == 0, "R10", "no bits", rises, 0);
        chk(done_n == 0, "R10", "no done", done_n, 0);
        chk(busy_n == LATCH, "R10", "busy cycles", busy_n, LATCH);
    endtask

    task automatic t_ignore();
        launch(2'd0, 2, 8'd255, 8);
        repeat (60) @(negedge clk);
        mode = 2'd2; pix_count = 16'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_frame();
        chk(rx_bits == 48, "R6", "start while busy ignored", rx_bits, 48);
        chk(done_n == 1, "R6", "single done", done_n, 1);
        chk(rx_pix[1] == exp_word(src_mem[1], 8'd255), "R6", "pixel intact", rx_pix[1], exp_word(src_mem[1], 8'd255));
        repeat (5) @(negedge clk);
        chk(busy == 0, "R6", "stays idle", busy, 0);
    endtask

    task automatic t_underrun();
        launch(2'd0, 4, 8'd255, 2);
        finish_frame();
        chk(urun_n == 1, "R11", "underrun pulse", urun_n, 1);
        chk(done_n == 0, "R11", "no done", done_n, 0);
        chk(rx_bits == 48, "R11", "bits before stop", rx_bits, 48);
        chk(tail_n == LATCH, "R11", "latch after underrun", tail_n, LATCH);
        chk(hs_n == 2, "R7", "handshakes", hs_n, 2);
    endtask

    initial begin
        src_mem[0] = 24'hC3_5A_0F; src_mem[1] = 24'h81_7E_FF;
        src_mem[2] = 24'h00_FF_01; src_mem[3] = 24'hA5_3C_96;
        src_mem[4] = 24'h12_34_56; src_mem[5] = 24'hFE_01_80;
        src_mem[6] = 24'h77_88_99; src_mem[7] = 24'h0F_F0_3C;
        t_reset();
        t_stream(3, 8'd255);
        t_stream(2, 8'd128);
        t_stream(2, 8'd0);
        t_repeat();
        t_clear();
        t_zero();
        t_ignore();
        t_underrun();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule